// File: doc/BRIEF.md
# Trie Longest Prefix Match Engine

The engine maps a 32-bit IPv4 destination address to a route value by walking a three-level trie stored in an external lookup memory. The trie uses strides of 16, 8 and 8 bits. Every memory word is either a leaf that carries the route value, or an internal node that carries a base pointer. When a node is returned, the engine reads again at that pointer plus the next address byte. A lookup ends at the first leaf it meets, so it costs one, two or three reads.

All lookups share one memory port. The memory answers a fixed number of cycles after each request, so several lookups are in flight at once and they circulate around a loop. A small queue travels in step with the memory pipeline. For each outstanding read it keeps the address bits not yet consumed, the tag, and the trie level. A response that does not finish its lookup has first claim on the port over a new address. A response that finishes its lookup leaves the port free, so a new address can enter in that same cycle. Finished results wait in a result queue that feeds a valid/ready output. They may leave in a different order from the one in which the addresses arrived, and the tag identifies each one.

Top module: `lpm_trie_walker`

## Requirements
- R1: An accepted address issues its first read in the cycle it is accepted. The read address is address bits [31:16], zero-extended to the memory address width.
- R2: A returned word with bit 31 clear is a node. The next read address is word bits [AW-1:0] plus the next address byte. That byte is bits [15:8] for the second read and bits [7:0] for the third.
- R3: A returned word with bit 31 set is a leaf. Its bits [30:0] become the result value, under the tag of its lookup, and that lookup issues no further read.
- R4: When a node word returns, the follow-on read takes the memory port in that cycle and in_ready is low.
- R5: When a leaf word returns, in_ready may be high in that same cycle, and a waiting address issues its first read alongside the exit.
- R6: The number of lookups in flight plus the results not yet delivered never exceeds MEM_LAT+1. in_ready is low while that limit is reached.
- R7: While out_valid is high and out_ready is low, out_valid, out_value and out_tag hold steady, and no result is lost.
- R8: A lookup makes exactly one read per level down to its first leaf, and never more than three. A third-level word is always a leaf.
- R9: During and just after reset, out_valid and mem_req_valid are low and in_ready is high.
- R10: New addresses can be accepted on back-to-back cycles while earlier reads are still outstanding, up to MEM_LAT of them before the first response returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Address offered |
| in_ready | output | 1 | Address taken this cycle when in_valid is high |
| in_addr | input | 32 | IPv4 destination address |
| in_tag | input | TAG_W | Caller label returned with the result |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_value | output | 31 | Route value from the leaf word |
| out_tag | output | TAG_W | Label of the finished lookup |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_addr | output | AW | Memory read address |
| mem_rsp_valid | input | 1 | Read data returned, MEM_LAT cycles after the request |
| mem_rsp_data | input | 32 | Returned word: bit 31 leaf flag, bits [30:0] value or pointer |

## Verification
The hardest cases to reach from the ports are the two cycles in which a memory response and a waiting address arrive together. In one, the response is a node and must win the port. In the other, the response is a leaf and must share the cycle with the new address. The bench holds in_valid low until it sees mem_rsp_valid, then raises it in that same cycle, once behind a one-read lookup and once behind a pointer word. It then checks in_ready and the issued read address before the clock edge. The admission limit is reached by stalling the output and pushing addresses until in_ready stays low.

// File: rtl/lpm_pkg.sv
// Shared constants for the trie walker: memory word layout, stride and level codes.
// Assumes 32-bit memory words and a 16/8/8 split of the IPv4 address.
package lpm_pkg;
    localparam int WORD_W   = 32;
    localparam int LEAF_BIT = 31;
    localparam int STRIDE   = 8;
    localparam int REM_W    = 16;

    typedef logic [1:0] lvl_t;
    localparam lvl_t LVL_FIRST = 2'd1;
    localparam lvl_t LVL_LAST  = 2'd3;
endpackage

// File: rtl/lpm_fifo.sv
// Circular FIFO with a registered head and an exposed occupancy count.
// Assumes the caller never pushes when full unless it pops in the same cycle,
// and never pops when empty.
module lpm_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count
);
    logic [W-1:0]  store_q [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;

    // Write the storage slot on push.
    always_ff @(posedge clk) begin
        if (push) store_q[wr_ptr] <= din;
    end

    // Advance the pointers and track the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Present the oldest entry.
    assign dout = store_q[rd_ptr];
endmodule

// File: rtl/lpm_step.sv
// Decodes one returned trie word and forms the follow-on read.
// Assumes the unconsumed address bits hold the next byte at [15:8].
module lpm_step
    import lpm_pkg::*;
#(
    parameter int AW = 17
) (
    input  logic [WORD_W-1:0] word,
    input  logic [REM_W-1:0]  rem,
    output logic              is_leaf,
    output logic [WORD_W-2:0] leaf_val,
    output logic [AW-1:0]     next_addr,
    output logic [REM_W-1:0]  next_rem
);
    // Split the word and add the next address byte to the base pointer.
    always_comb begin
        is_leaf   = word[LEAF_BIT];
        leaf_val  = word[WORD_W-2:0];
        next_addr = word[AW-1:0] + AW'(rem[REM_W-1:REM_W-STRIDE]);
        next_rem  = rem << STRIDE;
    end
endmodule

// File: rtl/lpm_trie_walker.sv
// Circular-pipeline longest prefix match engine. New addresses and recirculating
// node reads share one fixed-latency memory port, and recirculation has priority.
// Leaf responses exit into a result queue. Admission keeps the in-flight count plus
// the waiting results within MEM_LAT+1, so neither queue can overflow.
// Assumes the memory returns one response per request, in order, after MEM_LAT cycles.
module lpm_trie_walker
    import lpm_pkg::*;
#(
    parameter int TAG_W   = 4,
    parameter int AW      = 17,
    parameter int MEM_LAT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [31:0]       in_addr,
    input  logic [TAG_W-1:0]  in_tag,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [30:0]       out_value,
    output logic [TAG_W-1:0]  out_tag,
    output logic              mem_req_valid,
    output logic [AW-1:0]     mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data
);
    localparam int DEPTH = MEM_LAT + 1;
    localparam int CW    = $clog2(DEPTH + 1);
    localparam int ENT_W = TAG_W + REM_W + 2;
    localparam int RES_W = TAG_W + WORD_W - 1;

    logic [ENT_W-1:0] rq_din, rq_head;
    logic [CW-1:0]    rq_count, oq_count;
    logic [RES_W-1:0] oq_din, oq_head;

    logic [TAG_W-1:0] head_tag;
    logic [REM_W-1:0] head_rem;
    lvl_t             head_lvl;

    logic              is_leaf;
    logic [WORD_W-2:0] leaf_val;
    logic [AW-1:0]     next_addr;
    logic [REM_W-1:0]  next_rem;

    logic rsp_exit, rsp_recirc, accept, oq_pop;
    logic [CW:0] occupancy;

    assign {head_tag, head_rem, head_lvl} = rq_head;

    lpm_step #(.AW(AW)) step_i (
        .word      (mem_rsp_data),
        .rem       (head_rem),
        .is_leaf   (is_leaf),
        .leaf_val  (leaf_val),
        .next_addr (next_addr),
        .next_rem  (next_rem)
    );

    // Arbitrate the memory port: a recirculating node read beats a new address.
    always_comb begin
        rsp_exit      = mem_rsp_valid && is_leaf;
        rsp_recirc    = mem_rsp_valid && !is_leaf;
        occupancy     = {1'b0, rq_count} + {1'b0, oq_count};
        in_ready      = !rsp_recirc && (occupancy < (CW+1)'(DEPTH));
        accept        = in_valid && in_ready;
        mem_req_valid = rsp_recirc || accept;
        mem_req_addr  = rsp_recirc ? next_addr : AW'(in_addr[31:16]);
        rq_din        = rsp_recirc ? {head_tag, next_rem, lvl_t'(head_lvl + 2'd1)}
                                   : {in_tag, in_addr[REM_W-1:0], LVL_FIRST};
        oq_din        = {head_tag, leaf_val};
        oq_pop        = out_valid && out_ready;
    end

    lpm_fifo #(.W(ENT_W), .DEPTH(DEPTH)) recirc_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (mem_req_valid),
        .din   (rq_din),
        .pop   (mem_rsp_valid),
        .dout  (rq_head),
        .count (rq_count)
    );

    lpm_fifo #(.W(RES_W), .DEPTH(DEPTH)) result_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rsp_exit),
        .din   (oq_din),
        .pop   (oq_pop),
        .dout  (oq_head),
        .count (oq_count)
    );

    // Drive the result stream from the result queue head.
    always_comb begin
        out_valid            = (oq_count != '0);
        {out_tag, out_value} = oq_head;
    end
endmodule

// File: rtl/lpm_trie_walker_chk.sv
// Property checker for the trie walker, bound to every instance of the top module.
// Tracks accepted-but-undelivered lookups at the ports to bound occupancy.
module lpm_trie_walker_chk
    import lpm_pkg::*;
#(
    parameter int TAG_W   = 4,
    parameter int AW      = 17,
    parameter int MEM_LAT = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [15:0]      first_idx,
    input logic             out_valid,
    input logic             out_ready,
    input logic [30:0]      out_value,
    input logic [TAG_W-1:0] out_tag,
    input logic             mem_req_valid,
    input logic [AW-1:0]    mem_req_addr,
    input logic             mem_rsp_valid,
    input logic             rsp_leaf,
    input lvl_t             head_lvl
);
    localparam int DEPTH = MEM_LAT + 1;
    logic [7:0] live;

    // Count lookups accepted and not yet delivered.
    always_ff @(posedge clk) begin
        if (!rst_n) live <= '0;
        else        live <= live + 8'(in_valid && in_ready) - 8'(out_valid && out_ready);
    end

    // R1
    first_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> (mem_req_valid && mem_req_addr == AW'(first_idx)));

    // R3
    leaf_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rsp_valid && rsp_leaf && !(in_valid && in_ready)) |-> !mem_req_valid);

    // R4
    recirc_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rsp_valid && !rsp_leaf) |-> (!in_ready && mem_req_valid));

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live <= 8'(DEPTH));

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_value) && $stable(out_tag)));

    // R8
    third_leaf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rsp_valid && head_lvl == LVL_LAST) |-> rsp_leaf);
endmodule

bind lpm_trie_walker lpm_trie_walker_chk #(
    .TAG_W(TAG_W), .AW(AW), .MEM_LAT(MEM_LAT)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .first_idx     (in_addr[31:16]),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_value     (out_value),
    .out_tag       (out_tag),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .rsp_leaf      (mem_rsp_data[31]),
    .head_lvl      (head_lvl)
);

// File: tb/lpm_trie_walker_tb_top.sv
// Bench for the trie walker: a fixed-latency memory model holding a small trie,
// a vector table walked back to back, then directed tests of the port conflicts.
module lpm_trie_walker_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TAG_W = 4;
    localparam int AW    = 17;
    localparam int LAT   = 4;
    localparam logic [31:0] LEAF = 32'h8000_0000;

    localparam logic [31:0] VEC_ADDR [8] = '{32'h0A12_C805, 32'h0A12_C809, 32'h0A12_0701,
        32'h0507_0101, 32'h070E_0703, 32'h070E_0704, 32'h070E_0909, 32'h0102_0304};
    localparam logic [30:0] VEC_VAL [8] = '{31'hC5, 31'hC0, 31'hA0, 31'h55,
        31'hD3, 31'hD0, 31'hB0, 31'h7FF};
    localparam int VEC_RD [8] = '{3, 3, 2, 1, 3, 3, 2, 1};

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, out_ready = 1'b1;
    logic [31:0] in_addr = '0;
    logic [TAG_W-1:0] in_tag = '0;
    logic in_ready, out_valid, mem_req_valid, mem_rsp_valid;
    logic [30:0] out_value;
    logic [TAG_W-1:0] out_tag;
    logic [AW-1:0] mem_req_addr;
    logic [31:0] mem_rsp_data;

    logic          st_v [LAT];
    logic [AW-1:0] st_a [LAT];

    int errs = 0, checks = 0, cyc = 0, req_cnt = 0, total_out = 0;
    int got_cnt [16];
    logic [30:0] got_val [16];
    int acc_cyc [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    lpm_trie_walker #(.TAG_W(TAG_W), .AW(AW), .MEM_LAT(LAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_addr(in_addr), .in_tag(in_tag), .out_valid(out_valid), .out_ready(out_ready),
        .out_value(out_value), .out_tag(out_tag), .mem_req_valid(mem_req_valid),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    // Small trie: 10.18/16 and 7.14/16 point to second-level blocks, 5.7/16 is a leaf.
    function automatic logic [31:0] mem_word(input logic [AW-1:0] a);
        if (!a[16]) begin
            case (a[15:0])
                16'h0A12: return 32'h0001_0000;
                16'h070E: return 32'h0001_0100;
                16'h0507: return LEAF | 32'h55;
                default:  return LEAF | 32'h7FF;
            endcase
        end
        case (a[15:8])
            8'h00:   return (a[7:0] == 8'hC8) ? 32'h0001_0200 : (LEAF | 32'hA0);
            8'h01:   return (a[7:0] == 8'h07) ? 32'h0001_0300 : (LEAF | 32'hB0);
            8'h02:   return (a[7:0] == 8'h05) ? (LEAF | 32'hC5) : (LEAF | 32'hC0);
            8'h03:   return (a[7:0] == 8'h03) ? (LEAF | 32'hD3) : (LEAF | 32'hD0);
            default: return LEAF;
        endcase
    endfunction

    // Fixed-latency memory model.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) st_v[i] <= 1'b0;
        end else begin
            st_v[0] <= mem_req_valid;
            st_a[0] <= mem_req_addr;
            for (int i = 1; i < LAT; i++) begin
                st_v[i] <= st_v[i-1];
                st_a[i] <= st_a[i-1];
            end
        end
    end
    assign mem_rsp_valid = st_v[LAT-1];
    assign mem_rsp_data  = mem_word(st_a[LAT-1]);

    // Result and request monitor, sampled mid-cycle.
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            if (mem_req_valid) req_cnt++;
            if (out_valid && out_ready) begin
                got_val[out_tag] = out_value;
                got_cnt[out_tag]++;
                total_out++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_got();
        for (int i = 0; i < 16; i++) got_cnt[i] = 0;
        total_out = 0;
    endtask

    task automatic send(input logic [31:0] a, input logic [TAG_W-1:0] t, output int when);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a; in_tag = t;
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
        when = cyc;
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic wait_out(input int n);
        int t = 0;
        while (total_out < n && t < 500) begin @(negedge clk); t++; end
        #3;
    endtask

    task automatic wait_rsp();
        @(negedge clk);
        while (!mem_rsp_valid) @(negedge clk);
    endtask

    initial begin
        int w, exp_reads, acc;
        logic [30:0] held_val;
        logic [TAG_W-1:0] held_tag;
        // R9: reset state
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        chk(out_valid == 1'b0, "R9", "out_valid in reset", out_valid, 0);
        chk(mem_req_valid == 1'b0, "R9", "mem_req_valid in reset", mem_req_valid, 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(in_ready == 1'b1, "R9", "in_ready after reset", in_ready, 1);
        chk(out_valid == 1'b0, "R9", "out_valid after reset", out_valid, 0);

        // Vector table walked back to back: R2, R3, R8, R10
        clear_got();
        req_cnt = 0;
        exp_reads = 0;
        for (int i = 0; i < 8; i++) begin
            send(VEC_ADDR[i], TAG_W'(i), w);
            acc_cyc[i] = w;
            exp_reads += VEC_RD[i];
        end
        wait_out(8);
        for (int i = 0; i < 8; i++) begin
            chk(got_cnt[i] == 1, "R3", "one result per tag", got_cnt[i], 1);
            chk(got_val[i] == VEC_VAL[i], (VEC_RD[i] > 1) ? "R2" : "R3",
                "route value", got_val[i], VEC_VAL[i]);
        end
        chk(req_cnt == exp_reads, "R8", "total memory reads", req_cnt, exp_reads);
        chk(acc_cyc[3] - acc_cyc[0] == 3, "R10", "four accepts back to back",
            acc_cyc[3] - acc_cyc[0], 3);

        // R5: leaf response and a new address in the same cycle
        clear_got();
        send(32'h0507_0101, 4'd9, w);
        wait_rsp();
        in_valid = 1'b1; in_addr = 32'h0102_0304; in_tag = 4'd10;
        #1;
        chk(in_ready == 1'b1, "R5", "in_ready on leaf exit", in_ready, 1);
        chk(mem_req_valid && mem_req_addr == 17'h0102, "R1", "first read address",
            mem_req_addr, 17'h0102);
        @(posedge clk); #1;
        in_valid = 1'b0;
        wait_out(2);
        chk(got_cnt[9] == 1 && got_val[9] == 31'h55, "R5", "exiting result", got_val[9], 31'h55);
        chk(got_cnt[10] == 1 && got_val[10] == 31'h7FF, "R5", "entering result", got_val[10], 31'h7FF);

        // R4: node response wins the port over a new address
        clear_got();
        send(32'h0A12_C805, 4'd11, w);
        wait_rsp();
        in_valid = 1'b1; in_addr = 32'h0507_0909; in_tag = 4'd12;
        #1;
        chk(in_ready == 1'b0, "R4", "in_ready on recirculation", in_ready, 0);
        chk(mem_req_valid == 1'b1, "R4", "recirculation request", mem_req_valid, 1);
        chk(mem_req_addr == 17'h100C8, "R2", "second read address", mem_req_addr, 17'h100C8);
        while (!in_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        in_valid = 1'b0;
        wait_out(2);
        chk(got_val[11] == 31'hC5, "R4", "recirculated result", got_val[11], 31'hC5);
        chk(got_val[12] == 31'h55, "R4", "delayed entry result", got_val[12], 31'h55);

        // R6, R7: stall the output, count admissions, check hold
        clear_got();
        out_ready = 1'b0;
        acc = 0;
        for (int c = 0; c < 30; c++) begin
            @(negedge clk);
            in_valid = 1'b1; in_addr = {24'h010203, 8'(acc)}; in_tag = TAG_W'(acc);
            #1;
            if (in_ready) acc++;
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
        chk(acc == LAT + 1, "R6", "admitted while stalled", acc, LAT + 1);
        @(negedge clk); #1;
        chk(in_ready == 1'b0, "R6", "in_ready at limit", in_ready, 0);
        held_val = out_value; held_tag = out_tag;
        chk(out_valid == 1'b1, "R7", "out_valid while stalled", out_valid, 1);
        repeat (5) @(negedge clk);
        #1;
        chk(out_valid && out_value == held_val && out_tag == held_tag, "R7",
            "held result", {out_tag, out_value}, {held_tag, held_val});
        out_ready = 1'b1;
        wait_out(LAT + 1);
        for (int i = 0; i <= LAT; i++)
            chk(got_cnt[i] == 1 && got_val[i] == 31'h7FF, "R7", "no result lost",
                got_cnt[i], 1);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 20000, 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule